// File: doc/BRIEF.md
# Data-Routed Priority Crossbar

This block connects a set of valid/ready sources to a set of valid/ready sinks without any storage. Each source presents a valid flag and a data word. The low-order bits of that word are the index of the sink the word is meant for, so no separate address field is carried. The routing is purely combinational. Inputs and readies settle to outputs and readies within the same cycle.

When several sources name the same sink in one cycle, the source with the lowest index wins. The other contenders see their ready held low until the sink is free of earlier claimants. A winning source sees the ready of its sink passed straight back, so a transfer happens exactly when that sink's valid and ready are high together. A word whose index bits name no existing sink is never delivered. Its source waits with ready low.

The block sits between producers and consumers that already hold their data steady under backpressure. It adds no latency and no buffering.

Top module: `xbar_route`

## Requirements
- R1: The destination of input i is the unsigned value of the low DEST_W bits of its data word, where DEST_W = max(1, ceil(log2(N_OUT))). The remaining data bits play no part in routing.
- R2: An input with valid low claims no output, blocks no other input, and sees its ready low.
- R3: Each output is granted to at most one input per cycle. Among valid inputs that name an output, the one with the lowest index is granted.
- R4: A valid input that names an in-range output already granted to a lower-index input sees its ready low.
- R5: A granted input's ready equals the ready of the output it was routed to.
- R6: An output granted to no input drives valid low and data all zeros.
- R7: A granted output drives valid high and the winning input's full data word unchanged.
- R8: A valid input whose destination index is N_OUT or greater is never granted, sees ready low, and changes no output.
- R9: Output readies affect only input readies. Changing them leaves every output valid and data value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inValid | input | N_IN | Per-input valid flag |
| inData | input | N_IN*DATA_W | Input data words; word i is at bits [i*DATA_W +: DATA_W] |
| inReady | output | N_IN | Per-input ready back to the sources |
| outValid | output | N_OUT | Per-output valid flag |
| outData | output | N_OUT*DATA_W | Output data words; word o is at bits [o*DATA_W +: DATA_W] |
| outReady | input | N_OUT | Per-output ready from the sinks |

## Verification
The embedded assertions continuously check four properties. No output is given to two inputs and no input to two outputs. An idle output carries zero data. A raised input ready always comes from a valid source with an in-range destination, and that destination's sink is ready. Which contender wins, whether the delivered word is intact, and whether the upper data bits leave routing alone can only be shown by the bench's scenarios against its own reference model. The same holds for ready-only changes leaving the outputs still.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;
  // Number of low data bits used as the destination index.
  function automatic int destBits(input int numOut);
    return (numOut > 1) ? $clog2(numOut) : 1;
  endfunction
endpackage

// File: rtl/xbar_route_arb.sv
module xbar_route_arb #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int DATA_W = 8,
  parameter int DEST_W = 2
) (
  input  logic [N_IN-1:0]        reqValid,
  input  logic [N_IN*DATA_W-1:0] reqData,
  output logic [N_OUT*N_IN-1:0]  grantMat
);
  logic [N_OUT-1:0]  busy;
  logic [DEST_W-1:0] dest;

  // Single ascending pass; first valid claimant of a free output takes it.
  always_comb begin
    busy     = '0;
    grantMat = '0;
    dest     = '0;
    for (int i = 0; i < N_IN; i++) begin
      dest = reqData[i*DATA_W +: DEST_W];
      if (reqValid[i] && (int'(dest) < N_OUT)) begin
        if (!busy[dest]) begin
          busy[dest]                    = 1'b1;
          grantMat[int'(dest)*N_IN + i] = 1'b1;
        end
      end
    end
  end

  genvar go, gi;
  generate
    for (go = 0; go < N_OUT; go++) begin : g_rowChk
      always_comb begin
        // R3
        single_winner_chk: assert ($onehot0(grantMat[go*N_IN +: N_IN]));
      end
    end
    for (gi = 0; gi < N_IN; gi++) begin : g_colChk
      logic [N_OUT-1:0] col;
      always_comb begin
        for (int o = 0; o < N_OUT; o++) col[o] = grantMat[o*N_IN + gi];
      end
      always_comb begin
        // R3
        single_route_chk: assert ($onehot0(col));
      end
    end
  endgenerate
endmodule

// File: rtl/xbar_route_dp.sv
module xbar_route_dp #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int DATA_W = 8,
  parameter int DEST_W = 2
) (
  input  logic [N_IN-1:0]         srcValid,
  input  logic [N_IN*DATA_W-1:0]  srcData,
  input  logic [N_OUT*N_IN-1:0]   grantMat,
  input  logic [N_OUT-1:0]        sinkReady,
  output logic [N_OUT-1:0]        sinkValid,
  output logic [N_OUT*DATA_W-1:0] sinkData,
  output logic [N_IN-1:0]         srcReady
);
  genvar go, gi;
  generate
    for (go = 0; go < N_OUT; go++) begin : g_out
      logic              v;
      logic [DATA_W-1:0] d;
      always_comb begin
        v = 1'b0;
        d = '0;
        for (int i = 0; i < N_IN; i++) begin
          if (grantMat[go*N_IN + i]) begin
            v = v | srcValid[i];
            d = d | srcData[i*DATA_W +: DATA_W];
          end
        end
      end
      assign sinkValid[go]                    = v;
      assign sinkData[go*DATA_W +: DATA_W]    = d;

      always_comb begin
        // R6
        idle_zero_chk: assert (sinkValid[go] || (sinkData[go*DATA_W +: DATA_W] == '0));
      end
    end

    for (gi = 0; gi < N_IN; gi++) begin : g_in
      logic              r;
      logic [DEST_W-1:0] dst;
      always_comb begin
        r = 1'b0;
        for (int o = 0; o < N_OUT; o++) r = r | (grantMat[o*N_IN + gi] & sinkReady[o]);
      end
      assign srcReady[gi] = r;
      assign dst = srcData[gi*DATA_W +: DEST_W];

      always_comb begin
        // R2
        ready_needs_valid_chk: assert (!srcReady[gi] || srcValid[gi]);
        // R8
        ready_in_range_chk: assert (!srcReady[gi] || (int'(dst) < N_OUT));
        // R5
        if (srcReady[gi] && (int'(dst) < N_OUT)) begin
          ready_follows_sink_chk: assert (sinkReady[dst]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int DATA_W = 8
) (
  input  logic [N_IN-1:0]         inValid,
  input  logic [N_IN*DATA_W-1:0]  inData,
  output logic [N_IN-1:0]         inReady,
  output logic [N_OUT-1:0]        outValid,
  output logic [N_OUT*DATA_W-1:0] outData,
  input  logic [N_OUT-1:0]        outReady
);
  localparam int DEST_W = xbar_route_pkg::destBits(N_OUT);

  logic [N_OUT*N_IN-1:0] grantMat;

  xbar_route_arb #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_arb (
    .reqValid (inValid),
    .reqData  (inData),
    .grantMat (grantMat)
  );

  xbar_route_dp #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_dp (
    .srcValid  (inValid),
    .srcData   (inData),
    .grantMat  (grantMat),
    .sinkReady (outReady),
    .sinkValid (outValid),
    .sinkData  (outData),
    .srcReady  (inReady)
  );
endmodule

// File: tb/xbar_route_tb.sv
`timescale 1ns/1ps
module xbar_route_tb;
  localparam int N  = 4;
  localparam int M  = 3;
  localparam int W  = 8;
  localparam int DW = (M > 1) ? $clog2(M) : 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]   inValid  = '0;
  logic [N*W-1:0] inData   = '0;
  logic [N-1:0]   inReady;
  logic [M-1:0]   outValid;
  logic [M*W-1:0] outData;
  logic [M-1:0]   outReady = '0;

  xbar_route #(.N_IN(N), .N_OUT(M), .DATA_W(W)) u_dut (
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int destOf(input int i);
    return int'(inData[i*W +: W]) % (1 << DW);
  endfunction

  // Behavioural reference compared at every negedge.
  task automatic compareAll();
    int owner[M];
    for (int o = 0; o < M; o++) owner[o] = -1;
    for (int i = 0; i < N; i++)
      if (inValid[i] && destOf(i) < M && owner[destOf(i)] < 0) owner[destOf(i)] = i;
    for (int o = 0; o < M; o++) begin
      if (owner[o] < 0) begin
        chk("R6 idle valid", int'(outValid[o]), 0);
        chk("R6 idle data", int'(outData[o*W +: W]), 0);
      end else begin
        chk("R7/R3 winner valid", int'(outValid[o]), 1);
        chk("R7/R3 winner data", int'(outData[o*W +: W]), int'(inData[owner[o]*W +: W]));
      end
    end
    for (int i = 0; i < N; i++) begin
      if (!inValid[i])               chk("R2 ready", int'(inReady[i]), 0);
      else if (destOf(i) >= M)       chk("R8 ready", int'(inReady[i]), 0);
      else if (owner[destOf(i)] == i) chk("R5 ready", int'(inReady[i]), int'(outReady[destOf(i)]));
      else                           chk("R4 ready", int'(inReady[i]), 0);
    end
  endtask

  task automatic apply(input logic [N-1:0] v, input logic [N*W-1:0] d, input logic [M-1:0] r);
    @(posedge clk);
    inValid  <= v;
    inData   <= d;
    outReady <= r;
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    logic [M*W-1:0] keepData;
    logic [M-1:0]   keepValid;
    // idle: nothing valid
    apply('0, '0, '0);
    chk("R2 idle outputs", int'(outValid), 0);
    // each input to its own output, input 3 out of range (dest 3)
    apply(4'b1111, {8'h13, 8'h22, 8'h41, 8'h80}, 3'b101);
    chk("R8 out-of-range no ready", int'(inReady[3]), 0);
    // all to output 1: input 0 wins
    apply(4'b1111, {8'h71, 8'h61, 8'h51, 8'h41}, 3'b010);
    chk("R3 lowest index wins", int'(outData[1*W +: W]), 'h41);
    chk("R4 loser blocked", int'(inReady[1]), 0);
    // invalid input 0 does not block input 1
    apply(4'b1110, {8'h00, 8'h00, 8'h95, 8'h35}, 3'b111);
    chk("R2 invalid does not block", int'(outData[1*W +: W]), 'h95);
    chk("R5 winner ready", int'(inReady[1]), 1);
    // upper bits ignored for routing
    apply(4'b0011, {8'h00, 8'h00, 8'hFA, 8'hF5}, 3'b000);
    chk("R1 upper bits ignored out1", int'(outData[1*W +: W]), 'hF5);
    chk("R1 upper bits ignored out2", int'(outData[2*W +: W]), 'hFA);
    // ready change only: outputs stay
    keepData  = outData;
    keepValid = outValid;
    apply(4'b0011, {8'h00, 8'h00, 8'hFA, 8'hF5}, 3'b111);
    chk("R9 data unchanged", int'(outData), int'(keepData));
    chk("R9 valid unchanged", int'(outValid), int'(keepValid));
    // random traffic
    for (int k = 0; k < 400; k++)
      apply(N'($urandom), (N*W)'({$urandom, $urandom}), M'($urandom));
    done = 1;
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end
endmodule